// File: doc/BRIEF.md
# Absolute Difference Row with Deferred Increment

This block produces the magnitude of the difference between a reference pixel and a current pixel, for four pixel lanes side by side. Each lane avoids the final carry-propagate increment that an exact absolute difference would normally need. Instead, it returns two results:

- an 8-bit partial magnitude;
- a one-bit correction.

Their arithmetic sum is the exact value of |reference − current|. The correction is meant to be folded into a downstream carry-save accumulation tree. There it costs one extra input bit instead of a full 8-bit adder per pixel.

The current pixel is supplied already bit-inverted, because the storage that holds it is expected to keep it in that form. The lane therefore needs no inverters on that path. Internally, each lane forms a 9-bit sum of the reference and the inverted current pixel. The carry out of that sum is the correction bit. The low eight bits are conditionally inverted under the negated carry to give the magnitude.

A test-only output per lane adds magnitude and correction, so the row can be checked on its own against the exact value. The block is purely combinational.

Top module: `adiff_row`

## Requirements
- R1: For every pair of 8-bit reference value R and current value C, magnitude plus correction on a lane equals |R − C| exactly.
- R2: The correction bit of a lane is 1 exactly when R > C, and 0 when R ≤ C.
- R3: When R ≤ C, the lane magnitude equals C − R.
- R4: When R > C, the lane magnitude equals R − C − 1, one less than the true difference.
- R5: When R equals C, both magnitude and correction are 0.
- R6: The current-pixel input of each lane carries the bitwise complement of C, and the result is computed as reference minus current. Example: R = 10 and C = 3 give magnitude 6 and correction 1. Swapping them gives magnitude 7 and correction 0.
- R7: Lane k uses bits [8k+7:8k] of both pixel buses and drives bits [8k+7:8k] of the magnitude bus and bit k of the correction bus. Changing another lane's inputs leaves lane k's outputs unchanged.
- R8: The check output of lane k, bits [8k+7:8k], equals that lane's magnitude plus its correction bit.
- R9: At the extremes, R = 255 with C = 0 gives magnitude 254 and correction 1. R = 0 with C = 255 gives magnitude 255 and correction 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_pix | input | 32 | Four reference pixels, lane k in bits [8k+7:8k] |
| cur_n_pix | input | 32 | Four bit-inverted current pixels, lane k in bits [8k+7:8k] |
| mag_out | output | 32 | Per-lane partial magnitude, one short of exact when the correction is set |
| corr_out | output | 4 | Per-lane correction bit, set when reference exceeds current |
| check_out | output | 32 | Test-only per-lane sum of magnitude and correction |

## Verification
The bench drives all 65536 reference/current pairs. This catches any design whose magnitude is off by one on one side of the comparison. The off-by-one side matters because a magnitude that already includes the increment would count the correction twice downstream.

Equal pixels, and the two extreme pairs 255/0 and 0/255, are tested directly. Equal pixels show whether the comparison treats equality as R ≤ C. A design that swapped the roles of reference and current would return 7 instead of 6 in the R = 10, C = 3 case. A design that inverted the current pixel a second time would fail nearly every pair.

Lanes are disturbed one at a time while the neighbouring outputs are watched. This exposes a miswired slice.

// File: rtl/adiff_pkg.sv
// Package: shared widths for the deferred-increment absolute difference row.
// Assumes unsigned pixels; the correction is always one bit wide.
package adiff_pkg;
    parameter int PIX_W_DEF = 8;
    parameter int LANES_DEF = 4;
endpackage

// File: rtl/adiff_elem.sv
// Module: one absolute-difference lane without the final incrementer.
// Assumes cur_n holds the bitwise complement of the current pixel.
// The exact |ref - cur| equals mag + corr; the addition is left to the consumer.
module adiff_elem #(
    parameter int PIX_W = adiff_pkg::PIX_W_DEF
) (
    input  logic [PIX_W-1:0] ref_px,
    input  logic [PIX_W-1:0] cur_n,
    output logic [PIX_W-1:0] mag,
    output logic             corr
);
    localparam int SUM_W = PIX_W + 1;

    logic [SUM_W-1:0] sum_w;

    // Purpose: ref plus inverted cur, keep the carry, fold low bits under ~carry.
    always_comb begin
        sum_w = {1'b0, ref_px} + {1'b0, cur_n};
        corr  = sum_w[PIX_W];
        mag   = sum_w[PIX_W-1:0] ^ {PIX_W{~sum_w[PIX_W]}};
    end
endmodule

// File: rtl/adiff_fold.sv
// Module: test-only folding of the correction bit into the magnitude.
// Assumes mag + corr never exceeds the pixel range (true for absolute differences).
module adiff_fold #(
    parameter int PIX_W = adiff_pkg::PIX_W_DEF
) (
    input  logic [PIX_W-1:0] mag,
    input  logic             corr,
    output logic [PIX_W-1:0] exact
);
    // Purpose: reconstruct the exact difference for standalone checking.
    always_comb begin
        exact = mag + {{(PIX_W-1){1'b0}}, corr};
    end
endmodule

// File: rtl/adiff_row.sv
// Module: row of LANES deferred-increment absolute-difference lanes.
// Assumes packed buses with lane k in slice [k*PIX_W +: PIX_W]; purely combinational.
module adiff_row #(
    parameter int PIX_W = adiff_pkg::PIX_W_DEF,
    parameter int LANES = adiff_pkg::LANES_DEF
) (
    input  logic [LANES*PIX_W-1:0] ref_pix,
    input  logic [LANES*PIX_W-1:0] cur_n_pix,
    output logic [LANES*PIX_W-1:0] mag_out,
    output logic [LANES-1:0]       corr_out,
    output logic [LANES*PIX_W-1:0] check_out
);
    // Purpose: one element and one test fold per lane.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        adiff_elem #(.PIX_W(PIX_W)) u_elem (
            .ref_px (ref_pix[k*PIX_W +: PIX_W]),
            .cur_n  (cur_n_pix[k*PIX_W +: PIX_W]),
            .mag    (mag_out[k*PIX_W +: PIX_W]),
            .corr   (corr_out[k])
        );
        adiff_fold #(.PIX_W(PIX_W)) u_fold (
            .mag   (mag_out[k*PIX_W +: PIX_W]),
            .corr  (corr_out[k]),
            .exact (check_out[k*PIX_W +: PIX_W])
        );
    end
endmodule

// File: rtl/adiff_row_chk.sv
// Module: assertion checker for adiff_row, attached by bind.
// Assumes a combinational block: immediate assertions once inputs are known.
module adiff_row_chk #(
    parameter int PIX_W = 8,
    parameter int LANES = 4
) (
    input logic [LANES*PIX_W-1:0] ref_pix,
    input logic [LANES*PIX_W-1:0] cur_n_pix,
    input logic [LANES*PIX_W-1:0] mag_out,
    input logic [LANES-1:0]       corr_out,
    input logic [LANES*PIX_W-1:0] check_out
);
    // Purpose: relate each lane's outputs to the true difference of its inputs.
    always_comb begin
        if (!$isunknown({ref_pix, cur_n_pix, mag_out, corr_out, check_out})) begin
            for (int k = 0; k < LANES; k++) begin
                logic [PIX_W:0] r_v;
                logic [PIX_W:0] c_v;
                logic [PIX_W:0] m_v;
                r_v = {1'b0, ref_pix[k*PIX_W +: PIX_W]};
                c_v = {1'b0, ~cur_n_pix[k*PIX_W +: PIX_W]};
                m_v = {1'b0, mag_out[k*PIX_W +: PIX_W]};
                assert_sum_exact_R1: assert ((m_v + {{PIX_W{1'b0}}, corr_out[k]}) ==
                    ((r_v > c_v) ? (r_v - c_v) : (c_v - r_v)));
                assert_corr_dir_R2: assert (corr_out[k] == (r_v > c_v));
                if (r_v <= c_v) begin
                    assert_mag_low_R3: assert (m_v == c_v - r_v);
                end else begin
                    assert_mag_high_R4: assert (m_v == r_v - c_v - 1'b1);
                end
                assert_fold_R8: assert (check_out[k*PIX_W +: PIX_W] ==
                    mag_out[k*PIX_W +: PIX_W] + {{(PIX_W-1){1'b0}}, corr_out[k]});
            end
        end
    end
endmodule

bind adiff_row adiff_row_chk #(.PIX_W(PIX_W), .LANES(LANES)) u_chk (.*);

// File: tb/adiff_row_bench.sv
// Bench: directed tests for adiff_row, one task per scenario.
module adiff_row_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [31:0] ref_pix, cur_n_pix, mag_out, check_out;
    logic [3:0]  corr_out;
    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    adiff_row u_adiff_row (
        .ref_pix(ref_pix), .cur_n_pix(cur_n_pix), .mag_out(mag_out),
        .corr_out(corr_out), .check_out(check_out)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 60000 && !done) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles, expected < 60000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_lane(input int k, input int r, input int c);
        logic [7:0] rb, cb;
        rb = r[7:0];
        cb = c[7:0];
        ref_pix[k*8 +: 8]   = rb;
        cur_n_pix[k*8 +: 8] = ~cb;
    endtask

    task automatic step();
        @(negedge clk);
        #2;
    endtask

    task automatic lane_expect(input string req, input int k, input int r, input int c);
        int d;
        d = (r > c) ? r - c : c - r;
        chk({req, " sum"}, int'(mag_out[k*8 +: 8]) + int'(corr_out[k]), d);
        chk({req, " corr"}, int'(corr_out[k]), (r > c) ? 1 : 0);
        chk({req, " mag"}, int'(mag_out[k*8 +: 8]), (r > c) ? d - 1 : d);
        chk({req, " R8 check"}, int'(check_out[k*8 +: 8]), d);
    endtask

    // Reset/idle state: zero reference with current 0 gives zeros (R5).
    task automatic t_idle();
        for (int k = 0; k < 4; k++) set_lane(k, 0, 0);
        step();
        chk("R5 idle mag", int'(mag_out), 0);
        chk("R5 idle corr", int'(corr_out), 0);
    endtask

    // All pairs, four current values at a time (R1, R2, R3, R4, R8).
    task automatic t_exhaustive();
        for (int r = 0; r < 256; r++) begin
            for (int c = 0; c < 256; c += 4) begin
                for (int k = 0; k < 4; k++) set_lane(k, r, c + k);
                #1;
                for (int k = 0; k < 4; k++) lane_expect("R1 R2 R3 R4", k, r, c + k);
            end
            step();
        end
    endtask

    // Equal pixels give zero magnitude and zero correction (R5).
    task automatic t_equal();
        for (int v = 0; v < 256; v += 51) begin
            for (int k = 0; k < 4; k++) set_lane(k, v, v);
            step();
            chk("R5 mag", int'(mag_out), 0);
            chk("R5 corr", int'(corr_out), 0);
        end
    endtask

    // Direction and complemented current input (R6).
    task automatic t_direction();
        set_lane(0, 10, 3);
        set_lane(1, 3, 10);
        step();
        chk("R6 mag fwd", int'(mag_out[7:0]), 6);
        chk("R6 corr fwd", int'(corr_out[0]), 1);
        chk("R6 mag rev", int'(mag_out[15:8]), 7);
        chk("R6 corr rev", int'(corr_out[1]), 0);
    endtask

    // Extremes (R9).
    task automatic t_extremes();
        set_lane(2, 255, 0);
        set_lane(3, 0, 255);
        step();
        chk("R9 mag max", int'(mag_out[23:16]), 254);
        chk("R9 corr max", int'(corr_out[2]), 1);
        chk("R9 mag min", int'(mag_out[31:24]), 255);
        chk("R9 corr min", int'(corr_out[3]), 0);
    endtask

    // Disturb one lane at a time; the others must hold (R7).
    task automatic t_lanes();
        for (int k = 0; k < 4; k++) set_lane(k, 40 + k, 20 + 3 * k);
        step();
        for (int j = 0; j < 4; j++) begin
            set_lane(j, 200, 7);
            step();
            for (int k = 0; k < 4; k++) begin
                if (k == j) lane_expect("R7 own", k, 200, 7);
                else lane_expect("R7 other", k, 40 + k, 20 + 3 * k);
            end
            set_lane(j, 40 + j, 20 + 3 * j);
        end
    endtask

    initial begin
        ref_pix = '0;
        cur_n_pix = '1;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_direction();
        t_extremes();
        t_equal();
        t_lanes();
        t_exhaustive();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule